// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration header of a single bus function. Software or a host bridge reaches it through two plain ports. The read port returns 1, 2 or 4 bytes taken from any offset and packs them little-endian. The write port stores 1, 2 or 4 bytes.

Each byte is either locked or open, and the rule that decides this depends on the header-type byte the block holds. The identity bytes (vendor, device, revision, class, header type, interrupt pin) come from parameters at reset. A full-word write to a base-address register or to the expansion-ROM register of an implemented region is masked on its way in. The size bits read back as zero and the type bits read back as set, which lets software learn the size of each region. After every accepted write, a one-cycle strobe reports the byte range that was written, so that an address decoder beside this block can re-evaluate its windows.

Top module: `cfg_space_file`

## Requirements
- R1: After reset, bytes 0x00–0x01 hold the vendor ID, 0x02–0x03 the device ID, 0x08 the revision, 0x09–0x0B the class code (low byte first), 0x0E the header type and 0x3D the interrupt pin. The register of each region with a nonzero size (region n at 0x10+4n for n=0..5, ROM region at 0x30) holds that region's type bits. Every other byte is zero.
- R2: A read returns byte offset+k in bits 8k+7:8k. A length code of 1 or 2 returns that many bytes with the upper bits zero. Every other length code returns 4 bytes. Offsets wrap modulo 256.
- R3: An ordinary write puts data bits 7:0 at the offset and each further byte at the next offset up. Length code 1 or 2 writes that many bytes, and every other code writes 4.
- R4: When the header byte is 0x00 or 0x80, ordinary writes leave these bytes unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D, 0x10–0x27 and 0x30–0x33.
- R5: For any other header byte, ordinary writes leave these bytes unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D and 0x38–0x3B.
- R6: A 4-byte write at 0x10..0x24 (4-aligned) to a region of nonzero size stores (data AND NOT(size−1)) OR type, whatever the header byte.
- R7: A 4-byte write at 0x30 to a ROM region of nonzero size stores data AND (NOT(size−1) OR 1), so bit 0 acts as an enable bit.
- R8: A 4-byte write to the register of a zero-size region is handled as an ordinary write under R3–R5.
- R9: A 2-byte write at an odd offset, or a 4-byte write at an offset that is not a multiple of 4, changes nothing and raises no strobe.
- R10: For each accepted write, the strobe is high for exactly the next cycle, with low bound = write offset and high bound = offset + length − 1. This holds even when every byte in the range is locked.
- R11: A read in the same cycle as a write to the same bytes returns the old contents. The new contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_off | input | 8 | Write byte offset |
| wr_len | input | 3 | Write length code (1, 2, otherwise 4) |
| wr_data | input | 32 | Write data, lowest byte first |
| rd_off | input | 8 | Read byte offset |
| rd_len | input | 3 | Read length code (1, 2, otherwise 4) |
| rd_data | output | 32 | Read data, little-endian, zero-filled |
| upd_pulse | output | 1 | One-cycle strobe after an accepted write |
| upd_lo | output | 8 | First byte offset of the last accepted write |
| upd_hi | output | 8 | Last byte offset of the last accepted write |

## Verification
A write and a read can land in the same cycle, and on the same bytes. The bench sets up this case on purpose by driving a word write and a read of that word together. It expects the old word during that cycle and the masked or byte-merged new word one cycle later. The random traffic also overlaps writes with strobe checks in the following cycle: a misaligned write must leave the strobe low, and an accepted write must raise it over the computed range. Two copies with different header bytes run side by side, so that the two locking rules and the shared register masking are judged on every write.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int NREG    = 7;   // six base registers plus the ROM register
    localparam int ROM_IDX = 6;
    localparam int LANES   = 4;
    localparam int NBYTES  = 256;

    typedef logic [NREG-1:0][31:0]  region_vec_t;
    typedef logic [NBYTES-1:0][7:0] image_t;

    typedef struct packed {
        logic       en;
        logic [7:0] off;
        logic [7:0] val;
    } lane_t;

    typedef struct packed {
        logic       hit;
        logic [2:0] idx;
    } region_sel_t;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_DROP,
        WP_BYTES,
        WP_REGION
    } wpath_e;

    // Length code to byte count: 1 and 2 as given, anything else is a word.
    function automatic logic [2:0] eff_len(input logic [2:0] len);
        case (len)
            3'd1:    return 3'd1;
            3'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic is_aligned(input logic [7:0] off, input logic [2:0] elen);
        case (elen)
            3'd1:    return 1'b1;
            3'd2:    return ~off[0];
            default: return off[1:0] == 2'b00;
        endcase
    endfunction

    function automatic logic plain_header(input logic [7:0] hdr);
        return (hdr == 8'h00) || (hdr == 8'h80);
    endfunction

    function automatic logic in_span(input logic [7:0] off, input logic [7:0] lo,
                                     input logic [7:0] hi);
        return (off >= lo) && (off <= hi);
    endfunction

    // Byte-wise lock rule (R4 for plain headers, R5 otherwise).
    function automatic logic byte_locked(input logic [7:0] hdr, input logic [7:0] off);
        logic common;
        common = in_span(off, 8'h00, 8'h03) | in_span(off, 8'h08, 8'h0B) |
                 (off == 8'h0E) | (off == 8'h3D);
        if (plain_header(hdr))
            return common | in_span(off, 8'h10, 8'h27) | in_span(off, 8'h30, 8'h33);
        return common | in_span(off, 8'h38, 8'h3B);
    endfunction

    function automatic region_sel_t region_of(input logic [7:0] off);
        region_sel_t s;
        s.hit = 1'b0;
        s.idx = 3'd0;
        if (in_span(off, 8'h10, 8'h27)) begin
            s.hit = 1'b1;
            s.idx = 3'((off - 8'h10) >> 2);
        end else if (in_span(off, 8'h30, 8'h33)) begin
            s.hit = 1'b1;
            s.idx = 3'(ROM_IDX);
        end
        return s;
    endfunction

    // Masked word for a region register write (R6, R7).
    function automatic logic [31:0] region_word(input region_sel_t s, input logic [31:0] val,
                                                input region_vec_t sizes,
                                                input region_vec_t types);
        logic [31:0] keep;
        keep = ~(sizes[s.idx] - 32'd1);
        if (s.idx == 3'(ROM_IDX))
            return val & (keep | 32'd1);
        return (val & keep) | types[s.idx];
    endfunction

    // Reset contents of the whole space (R1).
    function automatic image_t reset_image(input logic [15:0] vendor, input logic [15:0] device,
                                           input logic [7:0] rev, input logic [23:0] class_code,
                                           input logic [7:0] hdr, input logic [7:0] pin,
                                           input region_vec_t sizes, input region_vec_t types);
        image_t      img;
        int          base;
        logic [31:0] w;
        img      = '0;
        img[0]   = vendor[7:0];
        img[1]   = vendor[15:8];
        img[2]   = device[7:0];
        img[3]   = device[15:8];
        img[8]   = rev;
        img[9]   = class_code[7:0];
        img[10]  = class_code[15:8];
        img[11]  = class_code[23:16];
        img[14]  = hdr;
        img[61]  = pin;
        for (int r = 0; r < NREG; r++) begin
            base = (r == ROM_IDX) ? 'h30 : ('h10 + 4 * r);
            w    = (sizes[r] != 32'd0) ? types[r] : 32'd0;
            for (int b = 0; b < LANES; b++)
                img[base + b] = w[8*b +: 8];
        end
        return img;
    endfunction

endpackage

// File: rtl/cfgsp_wr_decode.sv
// Turns one write request into up to four byte lanes, choosing between the
// masked region-register path and the ordinary locked byte path.
module cfgsp_wr_decode
    import cfgsp_pkg::*;
#(
    parameter region_vec_t REGION_SIZE = '0,
    parameter region_vec_t REGION_TYPE = '0
) (
    input  logic                   wr_en,
    input  logic [7:0]             wr_off,
    input  logic [2:0]             wr_len,
    input  logic [31:0]            wr_data,
    input  logic [7:0]             hdr,
    output lane_t [LANES-1:0]      lanes,
    output logic                   accept,
    output logic [2:0]             elen
);

    wpath_e      path;
    region_sel_t sel;
    logic [31:0] word;
    logic [7:0]  live;

    always_comb begin
        live = '0;
        for (int r = 0; r < NREG; r++)
            live[r] = (REGION_SIZE[r] != 32'd0);
    end

    always_comb begin
        elen = eff_len(wr_len);
        sel  = region_of(wr_off);
        if (!wr_en)
            path = WP_IDLE;
        else if (!is_aligned(wr_off, elen))
            path = WP_DROP;                         // R9
        else if ((elen == 3'd4) && sel.hit && live[sel.idx])
            path = WP_REGION;                       // R6, R7
        else
            path = WP_BYTES;                        // R3, R8
        word = (path == WP_REGION) ? region_word(sel, wr_data, REGION_SIZE, REGION_TYPE)
                                   : wr_data;
    end

    assign accept = (path == WP_BYTES) || (path == WP_REGION);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [7:0] off_k;
            assign off_k         = wr_off + 8'(k);
            assign lanes[k].off  = off_k;
            assign lanes[k].val  = word[8*k +: 8];
            assign lanes[k].en   = (path == WP_REGION) ||
                                   ((path == WP_BYTES) && (3'(k) < elen) &&
                                    !byte_locked(hdr, off_k));
        end
    endgenerate

endmodule

// File: rtl/cfgsp_store.sv
// Byte array with reset image, four write lanes and four read taps.
module cfgsp_store
    import cfgsp_pkg::*;
#(
    parameter image_t INIT = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  lane_t [LANES-1:0]      lanes,
    input  logic [7:0]             rd_off,
    output logic [LANES-1:0][7:0]  rd_bytes,
    output logic [7:0]             hdr_byte
);

    image_t mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= INIT;
        end else begin
            for (int k = 0; k < LANES; k++)
                if (lanes[k].en)
                    mem[lanes[k].off] <= lanes[k].val;
        end
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_tap
            logic [7:0] a_k;
            assign a_k         = rd_off + 8'(k);    // wraps modulo 256 (R2)
            assign rd_bytes[k] = mem[a_k];
        end
    endgenerate

    assign hdr_byte = mem[8'h0E];

endmodule

// File: rtl/cfgsp_rd_port.sv
// Packs the read taps little-endian and clears the lanes beyond the length.
module cfgsp_rd_port
    import cfgsp_pkg::*;
(
    input  logic [2:0]             rd_len,
    input  logic [LANES-1:0][7:0]  rd_bytes,
    output logic [31:0]            rd_data
);

    logic [2:0] n;
    assign n = eff_len(rd_len);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_pack
            assign rd_data[8*k +: 8] = (3'(k) < n) ? rd_bytes[k] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/cfgsp_strobe.sv
// Registers the byte range of each accepted write as a one-cycle pulse (R10).
module cfgsp_strobe (
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic [7:0]  wr_off,
    input  logic [2:0]  elen,
    output logic        upd_pulse,
    output logic [7:0]  upd_lo,
    output logic [7:0]  upd_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_pulse <= 1'b0;
            upd_lo    <= 8'h00;
            upd_hi    <= 8'h00;
        end else begin
            upd_pulse <= accept;
            if (accept) begin
                upd_lo <= wr_off;
                upd_hi <= wr_off + 8'(elen) - 8'd1;
            end
        end
    end

endmodule

// File: rtl/cfg_space_file.sv
module cfg_space_file
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID   = 16'hA5C3,
    parameter logic [7:0]  REVISION    = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h020000,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    // index 0 is rightmost; index 6 is the ROM region
    parameter region_vec_t REGION_SIZE = {32'h0000_0800, 32'h0, 32'h0, 32'h0, 32'h0,
                                          32'h0000_1000, 32'h0000_0100},
    parameter region_vec_t REGION_TYPE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                          32'h0000_0008, 32'h0000_0001}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_off,
    input  logic [2:0]  wr_len,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_off,
    input  logic [2:0]  rd_len,
    output logic [31:0] rd_data,
    output logic        upd_pulse,
    output logic [7:0]  upd_lo,
    output logic [7:0]  upd_hi
);

    localparam image_t INIT_IMG = reset_image(VENDOR_ID, DEVICE_ID, REVISION, CLASS_CODE,
                                              HEADER_TYPE, INT_PIN, REGION_SIZE, REGION_TYPE);

    lane_t [LANES-1:0]     lanes;
    logic                  accept;
    logic [2:0]            elen;
    logic [LANES-1:0][7:0] rd_bytes;
    logic [7:0]            hdr_byte;

    cfgsp_wr_decode #(
        .REGION_SIZE (REGION_SIZE),
        .REGION_TYPE (REGION_TYPE)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_off  (wr_off),
        .wr_len  (wr_len),
        .wr_data (wr_data),
        .hdr     (hdr_byte),
        .lanes   (lanes),
        .accept  (accept),
        .elen    (elen)
    );

    cfgsp_store #(
        .INIT (INIT_IMG)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .lanes    (lanes),
        .rd_off   (rd_off),
        .rd_bytes (rd_bytes),
        .hdr_byte (hdr_byte)
    );

    cfgsp_rd_port u_rd (
        .rd_len   (rd_len),
        .rd_bytes (rd_bytes),
        .rd_data  (rd_data)
    );

    cfgsp_strobe u_stb (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .wr_off    (wr_off),
        .elen      (elen),
        .upd_pulse (upd_pulse),
        .upd_lo    (upd_lo),
        .upd_hi    (upd_hi)
    );

endmodule

// File: rtl/cfgsp_check.sv
module cfgsp_check
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h0,
    parameter logic [15:0] DEVICE_ID   = 16'h0,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter region_vec_t REGION_SIZE = '0,
    parameter region_vec_t REGION_TYPE = '0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [7:0]  wr_off,
    input logic [2:0]  wr_len,
    input logic [7:0]  rd_off,
    input logic [2:0]  rd_len,
    input logic [31:0] rd_data,
    input logic        upd_pulse,
    input logic [7:0]  upd_lo,
    input logic [7:0]  upd_hi
);

    a_r10_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> $past(wr_en));

    a_r10_low_is_offset: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> (upd_lo == $past(wr_off)));

    a_r10_span_shape: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> ((upd_hi - upd_lo) == 8'd0 || (upd_hi - upd_lo) == 8'd1 ||
                       (upd_hi - upd_lo) == 8'd3));

    a_r9_odd_half_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_len == 3'd2 && wr_off[0]) |=> !upd_pulse);

    a_r9_skewed_word_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_len != 3'd1 && wr_len != 3'd2 && wr_off[1:0] != 2'b00) |=> !upd_pulse);

    // identity bytes are locked under both rules (R4 and R5)
    a_r4_ident_fixed: assert property (@(posedge clk) disable iff (rst)
        (rd_off == 8'h00 && rd_len == 3'd4) |-> (rd_data == {DEVICE_ID, VENDOR_ID}));

    generate
        if (plain_header(HEADER_TYPE) && REGION_SIZE[0] != 32'd0) begin : g_bar0
            a_r6_bar0_low_bits: assert property (@(posedge clk) disable iff (rst)
                (rd_off == 8'h10 && rd_len == 3'd4) |->
                ((rd_data & (REGION_SIZE[0] - 32'd1)) == REGION_TYPE[0]));
        end
        if (plain_header(HEADER_TYPE) && REGION_SIZE[ROM_IDX] > 32'd2) begin : g_rom
            a_r7_rom_low_clear: assert property (@(posedge clk) disable iff (rst)
                (rd_off == 8'h30 && rd_len == 3'd4) |->
                ((rd_data & (REGION_SIZE[ROM_IDX] - 32'd1) & ~32'd1) == 32'd0));
        end
    endgenerate

endmodule

bind cfg_space_file cfgsp_check #(
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .HEADER_TYPE (HEADER_TYPE),
    .REGION_SIZE (REGION_SIZE),
    .REGION_TYPE (REGION_TYPE)
) u_check (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_off    (wr_off),
    .wr_len    (wr_len),
    .rd_off    (rd_off),
    .rd_len    (rd_len),
    .rd_data   (rd_data),
    .upd_pulse (upd_pulse),
    .upd_lo    (upd_lo),
    .upd_hi    (upd_hi)
);

// File: tb/cfg_space_file_test.sv
module cfg_space_file_test;
    import cfgsp_pkg::*;

    localparam logic [15:0] VEN = 16'h1D0F;
    localparam logic [15:0] DEV = 16'hA5C3;
    localparam logic [7:0]  REV = 8'h03;
    localparam logic [23:0] CLS = 24'h020000;
    localparam logic [7:0]  PIN = 8'h01;
    localparam logic [31:0] SZ [7] = '{32'h100, 32'h1000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h800};
    localparam logic [31:0] TY [7] = '{32'h1, 32'h8, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam region_vec_t P_SIZE = {32'h800, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h100};
    localparam region_vec_t P_TYPE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8, 32'h1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = 8'h00;
    logic [2:0]  wr_len = 3'd1;
    logic [31:0] wr_data = 32'h0;
    logic [7:0]  rd_off = 8'h00;
    logic [2:0]  rd_len = 3'd4;
    logic [31:0] rd_a, rd_b;
    logic        pulse_a, pulse_b;
    logic [7:0]  lo_a, hi_a, lo_b, hi_b;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [7:0] mdl [2][256];

    cfg_space_file #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .CLASS_CODE(CLS),
                     .HEADER_TYPE(8'h00), .INT_PIN(PIN), .REGION_SIZE(P_SIZE),
                     .REGION_TYPE(P_TYPE)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len),
        .wr_data(wr_data), .rd_off(rd_off), .rd_len(rd_len), .rd_data(rd_a),
        .upd_pulse(pulse_a), .upd_lo(lo_a), .upd_hi(hi_a));

    cfg_space_file #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .CLASS_CODE(CLS),
                     .HEADER_TYPE(8'h01), .INT_PIN(PIN), .REGION_SIZE(P_SIZE),
                     .REGION_TYPE(P_TYPE)) uut_b (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len),
        .wr_data(wr_data), .rd_off(rd_off), .rd_len(rd_len), .rd_data(rd_b),
        .upd_pulse(pulse_b), .upd_lo(lo_b), .upd_hi(hi_b));

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int bm_len(input logic [2:0] len);
        if (len == 3'd1) return 1;
        if (len == 3'd2) return 2;
        return 4;
    endfunction

    // dev 0 runs header 0x00 (R4 rule), dev 1 runs header 0x01 (R5 rule)
    function automatic bit bm_locked(input int dev, input int a);
        bit base;
        base = (a <= 3) || (a >= 8 && a <= 11) || a == 14 || a == 61;
        if (dev == 0) return base || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
        return base || (a >= 56 && a <= 59);
    endfunction

    task automatic bm_reset();
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 256; i++) mdl[d][i] = 8'h00;
            mdl[d][0] = VEN[7:0];  mdl[d][1] = VEN[15:8];
            mdl[d][2] = DEV[7:0];  mdl[d][3] = DEV[15:8];
            mdl[d][8] = REV;       mdl[d][9] = CLS[7:0];
            mdl[d][10] = CLS[15:8]; mdl[d][11] = CLS[23:16];
            mdl[d][14] = (d == 0) ? 8'h00 : 8'h01;
            mdl[d][61] = PIN;
            mdl[d][16] = 8'h01;    mdl[d][20] = 8'h08;
        end
    endtask

    task automatic bm_write(input int dev, input logic [7:0] off, input logic [2:0] len,
                            input logic [31:0] d, output logic took);
        int n, idx;
        logic [31:0] w, keep;
        n = bm_len(len);
        took = 1'b0;
        if (n == 2 && off[0]) return;
        if (n == 4 && off[1:0] != 2'b00) return;
        took = 1'b1;
        idx = -1;
        if (n == 4 && off >= 8'h10 && off < 8'h28) idx = (int'(off) - 16) / 4;
        else if (n == 4 && off >= 8'h30 && off < 8'h34) idx = 6;
        if (idx >= 0 && SZ[idx] != 32'd0) begin
            keep = ~(SZ[idx] - 32'd1);
            if (idx == 6) w = (d & keep) | (d & 32'd1);
            else          w = (d & keep) | TY[idx];
            for (int b = 0; b < 4; b++) mdl[dev][8'(int'(off) + b)] = w[8*b +: 8];
            return;
        end
        for (int b = 0; b < n; b++)
            if (!bm_locked(dev, int'(off) + b))
                mdl[dev][8'(int'(off) + b)] = d[8*b +: 8];
    endtask

    function automatic logic [31:0] bm_read(input int dev, input logic [7:0] off,
                                            input logic [2:0] len);
        logic [31:0] v;
        v = 32'h0;
        for (int b = 0; b < bm_len(len); b++) v[8*b +: 8] = mdl[dev][8'(int'(off) + b)];
        return v;
    endfunction

    task automatic chk_read(input logic [7:0] off, input logic [2:0] len, input string tag);
        @(negedge clk);
        rd_off = off; rd_len = len;
        #1;
        chk(tag, rd_a, bm_read(0, off, len));
        chk(tag, rd_b, bm_read(1, off, len));
    endtask

    task automatic do_write(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d);
        logic t0, t1;
        logic [7:0] hi;
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_len = len; wr_data = d;
        bm_write(0, off, len, d, t0);
        bm_write(1, off, len, d, t1);
        @(negedge clk);
        wr_en = 1'b0;
        hi = off + 8'(bm_len(len)) - 8'd1;
        chk("R9/R10 strobe a", {31'd0, pulse_a}, {31'd0, t0});
        chk("R9/R10 strobe b", {31'd0, pulse_b}, {31'd0, t1});
        if (t0) begin
            chk("R10 low bound", {24'd0, lo_a}, {24'd0, off});
            chk("R10 high bound", {24'd0, hi_a}, {24'd0, hi});
            chk("R10 high bound b", {24'd0, hi_b}, {24'd0, hi});
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [7:0]  off;
        logic [2:0]  len;
        logic [31:0] d;
        logic        tk;
        logic [2:0]  lens [6] = '{3'd1, 3'd2, 3'd4, 3'd4, 3'd3, 3'd0};
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bm_reset();

        // R1 reset state
        #1;
        chk("R10 idle after reset", {31'd0, pulse_a}, 32'd0);
        chk_read(8'h00, 3'd4, "R1 ident");
        chk("R1 ident literal", rd_a, 32'hA5C31D0F);
        chk_read(8'h08, 3'd4, "R1 class");
        chk("R1 class literal", rd_a, 32'h02000003);
        chk_read(8'h0C, 3'd4, "R1 header byte");
        chk("R1 header b literal", rd_b, 32'h00010000);
        chk_read(8'h10, 3'd4, "R1 bar0 type");
        chk("R1 bar0 literal", rd_a, 32'h00000001);
        chk_read(8'h14, 3'd4, "R1 bar1 type");
        chk_read(8'h30, 3'd4, "R1 rom");
        chk_read(8'h3C, 3'd4, "R1 pin");
        chk("R1 pin literal", rd_a, 32'h00000100);

        // R6 base register masking
        do_write(8'h10, 3'd4, 32'hFFFFFFFF);
        chk_read(8'h10, 3'd4, "R6 io bar");
        chk("R6 io bar literal", rd_a, 32'hFFFFFF01);
        do_write(8'h14, 3'd4, 32'hFFFFFFFF);
        chk_read(8'h14, 3'd4, "R6 mem bar");
        chk("R6 mem bar literal b", rd_b, 32'hFFFFF008);

        // R7 ROM enable bit
        do_write(8'h30, 3'd4, 32'hFFFFFFFF);
        chk_read(8'h30, 3'd4, "R7 rom all ones");
        chk("R7 rom literal", rd_a, 32'hFFFFF801);
        do_write(8'h30, 3'd4, 32'h12345670);
        chk_read(8'h30, 3'd4, "R7 rom disabled");
        chk("R7 rom literal 2", rd_a, 32'h12345000);

        // R8 unimplemented region falls to byte rules
        do_write(8'h18, 3'd4, 32'hA5A5A5A5);
        chk_read(8'h18, 3'd4, "R8 empty region");
        chk("R8 plain header locked", rd_a, 32'h0);
        chk("R8 other header open", rd_b, 32'hA5A5A5A5);

        // R4 / R5 locks
        do_write(8'h3C, 3'd1, 32'h0000000B);
        do_write(8'h3D, 3'd1, 32'h00000077);
        chk_read(8'h3C, 3'd2, "R4 pin locked line open");
        chk("R4 literal", rd_a, 32'h0000010B);
        do_write(8'h00, 3'd2, 32'h00000000);
        chk_read(8'h00, 3'd4, "R4 ident byte write");
        do_write(8'h11, 3'd1, 32'h00000055);
        chk_read(8'h10, 3'd4, "R4/R5 bar byte write");
        do_write(8'h38, 3'd1, 32'h00000099);
        chk_read(8'h38, 3'd1, "R5 rom area locked");
        chk("R5 literal b", rd_b, 32'h00000000);
        do_write(8'h0C, 3'd4, 32'h44332211);  // all-locked byte 0x0E inside
        chk_read(8'h0C, 3'd4, "R4/R5 header kept");

        // R9 misaligned writes ignored
        do_write(8'h41, 3'd2, 32'h0000BEEF);
        do_write(8'h42, 3'd4, 32'hDEADBEEF);
        chk_read(8'h40, 3'd4, "R9 nothing stored");
        chk("R9 literal", rd_a, 32'h0);

        // R3 / R10 odd length code acts as a word
        do_write(8'h40, 3'd3, 32'h11223344);
        chk("R10 word span", {24'd0, hi_a}, 32'h43);
        @(negedge clk);
        chk("R10 single cycle", {31'd0, pulse_a}, 32'd0);
        chk_read(8'h40, 3'd4, "R3 word order");
        chk("R3 literal", rd_a, 32'h11223344);

        // R2 lengths and wrap
        chk_read(8'h40, 3'd1, "R2 one byte");
        chk("R2 byte literal", rd_a, 32'h00000044);
        chk_read(8'h41, 3'd2, "R2 half unaligned");
        chk("R2 half literal", rd_a, 32'h00002233);
        chk_read(8'h40, 3'd7, "R2 other code");
        do_write(8'hFC, 3'd4, 32'hCAFEF00D);
        chk_read(8'hFE, 3'd4, "R2 wrap");
        chk("R2 wrap literal", rd_a, 32'h1D0FCAFE);

        // R11 read and write on the same word in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_off = 8'h44; wr_len = 3'd4; wr_data = 32'h0BADCAFE;
        rd_off = 8'h44; rd_len = 3'd4;
        #1;
        chk("R11 old value same cycle", rd_a, bm_read(0, 8'h44, 3'd4));
        bm_write(0, 8'h44, 3'd4, 32'h0BADCAFE, tk);
        bm_write(1, 8'h44, 3'd4, 32'h0BADCAFE, tk);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R11 new value next cycle", rd_a, 32'h0BADCAFE);
        chk("R11 new value next cycle b", rd_b, 32'h0BADCAFE);

        // random traffic
        for (int it = 0; it < 300; it++) begin
            off = ($urandom % 2) ? 8'($urandom % 64) : 8'($urandom % 256);
            len = lens[$urandom % 6];
            d   = ($urandom % 8 == 0) ? 32'hFFFFFFFF : $urandom;
            do_write(off, len, d);
            chk_read(off & 8'hFC, 3'd4, "R3/R6 random");
            chk_read(8'($urandom % 256), lens[$urandom % 6], "R2/R4/R5 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule